// File: doc/BRIEF.md
# In-Frame Response Receive Tracker

This block follows the receive side of a byte-oriented vehicle network data link (SAE J1850 class) through one message and its optional in-frame response. A bit-level front end hands it decoded symbol events: start of frame, end of data, end of frame, a received byte with its value, and an invalid-symbol error. The block keeps the last accepted byte in a data register. It shows the most urgent pending receive condition as a one-hot state vector and raises an interrupt while anything is pending.

Bytes that arrive between start of frame and end of data count as message bytes. Bytes that arrive after end of data count as response bytes. The end-of-data boundary is never shown as a state of its own: the first response byte itself marks it. The CPU can set a mask bit to hide the rest of the current frame. This covers bytes looped back from the block's own response transmitter, which enter through the same byte input. The mask clears itself on the next valid start of frame.

Top module: `ifr_rx_tracker`

## Requirements
- R1: After reset, `rx_state`, `data_reg`, `irq` and `mask_active` are all zero and the tracker waits for a start of frame.
- R2: In the cycle after a byte is accepted between a start of frame and an end of data, `data_reg` holds that byte and the message-byte bit (`rx_state[0]`) is pending.
- R3: An end of data only moves the tracker into the response phase and changes no output. Each byte accepted after it, up to end of frame, loads `data_reg` and pends the response-byte bit (`rx_state[1]`).
- R4: An end of frame seen after a start of frame pends the end-of-frame bit (`rx_state[2]`) and returns the tracker to waiting for a start of frame.
- R5: An invalid-symbol error pends the error bit (`rx_state[3]`), discards any byte in the same cycle (`data_reg` unchanged), and returns the tracker to waiting. Bytes, end of data and end of frame are ignored until the next start of frame.
- R6: `rx_state` shows only the highest-priority pending condition, in the order error, end of frame, received byte. Nothing pending gives all zeros.
- R7: A pulse on `data_rd` clears the pending byte condition, unless a byte is accepted in the same cycle, which wins. `irq` is high exactly while any condition is pending.
- R8: While `mask_active` is set, accepted bytes, end of frame and errors change neither `data_reg` nor `rx_state`. Bytes from the block's own response transmitter get no exemption.
- R9: A start of frame with no error in the same cycle clears the pending error and end-of-frame conditions and clears the mask. A `mask_wr` in the same cycle takes precedence for the mask.
- R10: A start of frame and an error in the same cycle count as an error only, and the tracker stays waiting. Bytes and end of frame that arrive while the tracker waits, or in a start-of-frame cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_sof | input | 1 | Start-of-frame symbol event |
| sym_eod | input | 1 | End-of-data symbol event |
| sym_eof | input | 1 | End-of-frame symbol event |
| sym_err | input | 1 | Invalid or out-of-range symbol event |
| byte_vld | input | 1 | A complete byte was received |
| byte_data | input | DATA_W | Value of the received byte |
| data_rd | input | 1 | CPU read of the data register |
| mask_wr | input | 1 | CPU write strobe for the mask bit |
| mask_wdata | input | 1 | Value written to the mask bit |
| data_reg | output | DATA_W | Last accepted byte |
| rx_state | output | 4 | One-hot: [0] message byte, [1] response byte, [2] end of frame, [3] error |
| irq | output | 1 | High while any condition is pending |
| mask_active | output | 1 | Current value of the mask bit |

## Verification
Two things can land on the same edge: a new byte and a CPU read of the data register. When they do, the fresh byte must stay pending and its value must be visible. The directed part drives a read and a response byte together and expects the response-byte state with the new value. The random part overlaps reads, bytes, end of frame, errors, start of frame and mask writes freely. Every cycle is judged against a bench model built from the rules above.

// File: rtl/ifr_rx_pkg.sv
package ifr_rx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MSG  = 2'd1,
        PH_IFR  = 2'd2
    } phase_e;

    localparam int ST_MSG = 0;
    localparam int ST_IFR = 1;
    localparam int ST_EOF = 2;
    localparam int ST_ERR = 3;
    localparam int NUM_ST = 4;

    // pending receive conditions
    typedef struct packed {
        logic err;
        logic eof;
        logic byte_p;
        logic is_ifr;
    } pend_t;

    // per-cycle decisions of the phase tracker
    typedef struct packed {
        logic sof_ok;
        logic take_byte;
        logic take_eof;
        logic byte_ifr;
    } evt_t;

    function automatic logic [NUM_ST-1:0] pick_state(input pend_t p);
        logic [NUM_ST-1:0] s;
        s = '0;
        if (p.err)         s[ST_ERR] = 1'b1;
        else if (p.eof)    s[ST_EOF] = 1'b1;
        else if (p.byte_p) s[p.is_ifr ? ST_IFR : ST_MSG] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/ifr_phase_fsm.sv
module ifr_phase_fsm
    import ifr_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic eod,
    input  logic eof,
    input  logic byte_vld,
    input  logic err,
    output evt_t evt
);
    phase_e ph_q, ph_d;
    logic   busy, quiet;

    always_comb begin
        busy          = (ph_q != PH_IDLE);
        quiet         = !err && !sof;
        evt.sof_ok    = sof && !err;
        evt.take_byte = byte_vld && quiet && busy;
        evt.take_eof  = eof && quiet && busy;
        evt.byte_ifr  = (ph_q == PH_IFR);

        if (err)                          ph_d = PH_IDLE;
        else if (sof)                     ph_d = PH_MSG;
        else if (eof && busy)             ph_d = PH_IDLE;
        else if (eod && ph_q == PH_MSG)   ph_d = PH_IFR;
        else                              ph_d = ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end
endmodule

// File: rtl/ifr_status_regs.sv
module ifr_status_regs
    import ifr_rx_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic              err,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd,
    input  logic              mask_wr,
    input  logic              mask_wdata,
    output pend_t             pend,
    output logic [DATA_W-1:0] data_q,
    output logic              mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            data_q <= '0;
            mask_q <= 1'b0;
        end else begin
            if (evt.sof_ok) begin
                pend.err <= 1'b0;
                pend.eof <= 1'b0;
            end
            if (err && !mask_q)          pend.err <= 1'b1;
            if (evt.take_eof && !mask_q) pend.eof <= 1'b1;
            if (evt.take_byte && !mask_q) begin
                data_q      <= byte_data;
                pend.byte_p <= 1'b1;
                pend.is_ifr <= evt.byte_ifr;
            end else if (rd) begin
                pend.byte_p <= 1'b0;
            end
            if (evt.sof_ok) mask_q <= 1'b0;
            if (mask_wr)    mask_q <= mask_wdata;
        end
    end
endmodule

// File: rtl/ifr_state_encoder.sv
module ifr_state_encoder
    import ifr_rx_pkg::*;
(
    input  pend_t             pend,
    output logic [NUM_ST-1:0] state,
    output logic              irq
);
    always_comb begin
        state = pick_state(pend);
        irq   = pend.err | pend.eof | pend.byte_p;
    end
endmodule

// File: rtl/ifr_rx_tracker.sv
module ifr_rx_tracker
    import ifr_rx_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_sof,
    input  logic              sym_eod,
    input  logic              sym_eof,
    input  logic              sym_err,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              data_rd,
    input  logic              mask_wr,
    input  logic              mask_wdata,
    output logic [DATA_W-1:0] data_reg,
    output logic [3:0]        rx_state,
    output logic              irq,
    output logic              mask_active
);
    evt_t  evt;
    pend_t pend;

    ifr_phase_fsm u_phase (
        .clk      (clk),
        .rst      (rst),
        .sof      (sym_sof),
        .eod      (sym_eod),
        .eof      (sym_eof),
        .byte_vld (byte_vld),
        .err      (sym_err),
        .evt      (evt)
    );

    ifr_status_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .err        (sym_err),
        .byte_data  (byte_data),
        .rd         (data_rd),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .pend       (pend),
        .data_q     (data_reg),
        .mask_q     (mask_active)
    );

    ifr_state_encoder u_enc (
        .pend  (pend),
        .state (rx_state),
        .irq   (irq)
    );
endmodule

// File: rtl/ifr_rx_tracker_chk.sv
module ifr_rx_tracker_chk #(
    parameter int DATA_W = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              sym_sof,
    input logic              sym_err,
    input logic              byte_vld,
    input logic              data_rd,
    input logic              mask_wr,
    input logic [DATA_W-1:0] data_reg,
    input logic [3:0]        rx_state,
    input logic              irq,
    input logic              mask_active
);
    // R6 / R7: one condition shown at most, irq tracks it
    p_state_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_state) && (irq == (rx_state != 4'b0000)));

    // R5: an unmasked error shows the error state and keeps the data
    p_err_drops_byte_r5: assert property (@(posedge clk) disable iff (rst)
        sym_err && !mask_active |=> (rx_state == 4'b1000) && $stable(data_reg));

    // R7: a read with no byte clears the byte conditions
    p_read_ack_r7: assert property (@(posedge clk) disable iff (rst)
        data_rd && !byte_vld |=> rx_state[1:0] == 2'b00);

    // R8: mask freezes state and data except on read or start of frame
    p_mask_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        mask_active && !sym_sof && !data_rd |=> $stable(rx_state) && $stable(data_reg));

    // R9: a valid start of frame lifts the mask
    p_sof_unmask_r9: assert property (@(posedge clk) disable iff (rst)
        sym_sof && !sym_err && !mask_wr |=> !mask_active);
endmodule

bind ifr_rx_tracker ifr_rx_tracker_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sym_sof     (sym_sof),
    .sym_err     (sym_err),
    .byte_vld    (byte_vld),
    .data_rd     (data_rd),
    .mask_wr     (mask_wr),
    .data_reg    (data_reg),
    .rx_state    (rx_state),
    .irq         (irq),
    .mask_active (mask_active)
);

// File: tb/ifr_rx_tracker_bench.sv
module ifr_rx_tracker_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          sym_sof, sym_eod, sym_eof, sym_err, byte_vld;
    logic [DW-1:0] byte_data;
    logic          data_rd, mask_wr, mask_wdata;
    logic [DW-1:0] data_reg;
    logic [3:0]    rx_state;
    logic          irq, mask_active;

    int checks = 0;
    int errors = 0;

    // bench model
    int            m_ph;      // 0 wait, 1 message, 2 response
    logic          m_err, m_eof, m_byte, m_ifr, m_mask;
    logic [DW-1:0] m_data;

    always #4 clk = ~clk;

    ifr_rx_tracker #(.DATA_W(DW)) u_ifr_rx_tracker (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_state();
        if (m_err)       return 4'b1000;
        else if (m_eof)  return 4'b0100;
        else if (m_byte) return m_ifr ? 4'b0010 : 4'b0001;
        return 4'b0000;
    endfunction

    task automatic chk_all();
        chk("R6 state", {28'd0, rx_state}, {28'd0, exp_state()});
        chk("R2 data", {24'd0, data_reg}, {24'd0, m_data});
        chk("R7 irq", {31'd0, irq}, {31'd0, (m_err | m_eof | m_byte)});
        chk("R9 mask", {31'd0, mask_active}, {31'd0, m_mask});
    endtask

    task automatic model_step();
        logic busy, quiet, sof_ok, tb, te;
        busy   = (m_ph != 0);
        quiet  = !sym_err && !sym_sof;
        sof_ok = sym_sof && !sym_err;
        tb     = byte_vld && quiet && busy;
        te     = sym_eof && quiet && busy;
        if (sof_ok) begin m_err = 0; m_eof = 0; end
        if (sym_err && !m_mask) m_err = 1;
        if (te && !m_mask) m_eof = 1;
        if (tb && !m_mask) begin
            m_data = byte_data; m_byte = 1; m_ifr = (m_ph == 2);
        end else if (data_rd) m_byte = 0;
        if (sof_ok) m_mask = 0;
        if (mask_wr) m_mask = mask_wdata;
        if (sym_err)                  m_ph = 0;
        else if (sym_sof)             m_ph = 1;
        else if (sym_eof && busy)     m_ph = 0;
        else if (sym_eod && m_ph == 1) m_ph = 2;
    endtask

    // one clock with the given inputs; returns just after the edge
    task automatic cyc(input logic sof, input logic eod, input logic eof,
                       input logic err, input logic bv, input logic [DW-1:0] bd,
                       input logic rd, input logic mw, input logic mwd);
        @(negedge clk);
        sym_sof = sof; sym_eod = eod; sym_eof = eof; sym_err = err;
        byte_vld = bv; byte_data = bd; data_rd = rd;
        mask_wr = mw; mask_wdata = mwd;
        model_step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle1();           cyc(0,0,0,0,0,8'h00,0,0,0); endtask
    task automatic sof1();            cyc(1,0,0,0,0,8'h00,0,0,0); endtask
    task automatic eod1();            cyc(0,1,0,0,0,8'h00,0,0,0); endtask
    task automatic eof1();            cyc(0,0,1,0,0,8'h00,0,0,0); endtask
    task automatic err1();            cyc(0,0,0,1,0,8'h00,0,0,0); endtask
    task automatic rd1();             cyc(0,0,0,0,0,8'h00,1,0,0); endtask
    task automatic byte1(input logic [DW-1:0] b); cyc(0,0,0,0,1,b,0,0,0); endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        sym_sof = 0; sym_eod = 0; sym_eof = 0; sym_err = 0; byte_vld = 0;
        byte_data = '0; data_rd = 0; mask_wr = 0; mask_wdata = 0;
        m_ph = 0; m_err = 0; m_eof = 0; m_byte = 0; m_ifr = 0; m_mask = 0; m_data = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset state", {28'd0, rx_state}, 32'h0);
        chk("R1 reset data", {24'd0, data_reg}, 32'h0);
        chk("R1 reset irq", {31'd0, irq}, 32'h0);
        chk("R1 reset mask", {31'd0, mask_active}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // byte before start of frame is ignored (R10)
        byte1(8'hA5);
        chk("R10 idle byte", {24'd0, data_reg}, 32'h00);
        // message byte (R2)
        sof1(); byte1(8'h11);
        chk("R2 msg state", {28'd0, rx_state}, 32'h1);
        chk("R2 msg data", {24'd0, data_reg}, 32'h11);
        rd1();
        chk("R7 read ack", {28'd0, rx_state}, 32'h0);
        chk("R7 irq low", {31'd0, irq}, 32'h0);
        // end of data shows nothing (R3)
        eod1();
        chk("R3 no eod state", {28'd0, rx_state}, 32'h0);
        byte1(8'h22);
        chk("R3 ifr state", {28'd0, rx_state}, 32'h2);
        // byte and read in the same cycle (R7)
        cyc(0,0,0,0,1,8'h33,1,0,0);
        chk("R7 byte beats read", {28'd0, rx_state}, 32'h2);
        chk("R3 ifr data", {24'd0, data_reg}, 32'h33);
        // end of frame outranks pending byte (R4, R6)
        eof1();
        chk("R4 eof state", {28'd0, rx_state}, 32'h4);
        rd1();
        chk("R6 eof after read", {28'd0, rx_state}, 32'h4);
        chk("R7 irq eof", {31'd0, irq}, 32'h1);
        byte1(8'h99);
        chk("R4 wait after eof", {24'd0, data_reg}, 32'h33);
        // end of frame with no response (R4)
        sof1();
        chk("R9 sof clears eof", {28'd0, rx_state}, 32'h0);
        eod1(); eof1();
        chk("R4 eof no ifr", {28'd0, rx_state}, 32'h4);
        // error drops byte (R5)
        sof1(); byte1(8'h44);
        cyc(0,0,0,1,1,8'h5A,0,0,0);
        chk("R5 err state", {28'd0, rx_state}, 32'h8);
        chk("R5 err data", {24'd0, data_reg}, 32'h44);
        byte1(8'h55);
        chk("R5 ignored after err", {24'd0, data_reg}, 32'h44);
        rd1();
        chk("R6 err over byte", {28'd0, rx_state}, 32'h8);
        // sof with error counts as error (R10)
        cyc(1,0,0,1,0,8'h00,0,0,0);
        byte1(8'h5B);
        chk("R10 sof+err stays idle", {24'd0, data_reg}, 32'h44);
        sof1();
        chk("R9 sof clears err", {28'd0, rx_state}, 32'h0);
        // masking (R8) including own response bytes
        cyc(0,0,0,0,0,8'h00,0,1,1);
        chk("R8 mask set", {31'd0, mask_active}, 32'h1);
        byte1(8'h66); eod1(); byte1(8'h77);
        chk("R8 masked data", {24'd0, data_reg}, 32'h44);
        eof1(); err1();
        chk("R8 masked state", {28'd0, rx_state}, 32'h0);
        chk("R8 masked irq", {31'd0, irq}, 32'h0);
        sof1();
        chk("R9 sof unmask", {31'd0, mask_active}, 32'h0);
        byte1(8'h88);
        chk("R9 live again", {24'd0, data_reg}, 32'h88);
        // mask write wins over sof (R9)
        cyc(1,0,0,0,0,8'h00,1,1,1);
        chk("R9 write beats sof", {31'd0, mask_active}, 32'h1);
        sof1();
        idle1();
        chk_all();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            cyc(r < 6, (r >= 15) && (r < 22), (r >= 9) && (r < 15), (r >= 6) && (r < 9),
                ($urandom % 100) < 45, 8'($urandom), ($urandom % 4) == 0,
                ($urandom % 40) == 0, 1'($urandom));
            chk_all();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule